// File: doc/BRIEF.md
# Rename history buffer with rollback

The block keeps an ordered list of rename records for one thread of an out-of-order core. Each record holds the sequence number of the instruction that renamed a destination, the architectural register, the physical register just allocated to it, and the physical register it displaced. Rename pushes a record on the young end every time it maps a destination. The map table and the free list live outside the block. This block only emits the writes they need.

Three kinds of request drain the list, each at one record per cycle while `busy` is high:

- **Commit** retires records from the old end. It returns each displaced register to the free list.
- **Squash** undoes records from the young end. For each one it rewrites the map entry with the displaced register and frees the new register. A new register that lies above the integer and floating-point register file is also marked ready.
- **Flush** undoes every record in the same way as a squash.

Commit numbers that are already behind the oldest record are tolerated and dropped.

The controller is a four-state machine:

- `ST_IDLE` accepts pushes and requests.
- `ST_COMMIT`, `ST_SQUASH` and `ST_FLUSH` each walk the list.

The transitions are as follows:

- *start-flush*: idle to flush, taken when a flush arrives and the list is not empty.
- *start-squash*: idle to squash, taken when a squash arrives and the youngest number exceeds the squash number.
- *start-commit*: idle to commit, taken when a plain commit arrives and the oldest number is at or below the commit number.
- *step*: a walk state to itself, taken while its condition holds. Each step emits one record and pops it.
- *done*: a walk state back to idle. This takes one cycle with no strobes, once the condition fails.

Top module: `rename_hist_buf`

## Requirements
- R1: A record is appended on the young end when `push_valid` is high and `push_ok` is high. `push_ok` is high only in idle, when fewer than DEPTH records are held, and when neither `squash_valid` nor `flush_valid` is high. `full` is high at DEPTH records, and a push while full is not stored.
- R2: A squash with number S undoes records from the youngest end while their number is greater than S (unsigned compare), one per cycle. Each undo pulses `map_wr_en` with `map_wr_areg`/`map_wr_preg` set to the record's architectural and displaced registers. In the same cycle it pulses `free_en` with `free_preg` set to the record's new register.
- R3: During an undo, `ready_en` pulses with `ready_preg` set to the new register exactly when that register index is at or above NUM_PHYS. Otherwise `ready_en` stays low.
- R4: A squash on an empty list, or one whose number is at or above the youngest record's number, produces no strobes and leaves `busy` low.
- R5: A commit with number C retires records from the oldest end while their number is at or below C, one per cycle. Each retirement pulses `free_en` with the displaced register, and `map_wr_en` stays low.
- R6: A commit is ignored, with no strobes and `busy` staying low, when the list is empty or the oldest record's number is greater than C.
- R7: A commit is ignored when `commit_squash` is high or `squash_valid` is high in the same cycle.
- R8: A flush undoes every record, youngest first, with the same strobes as R2 and R3, leaving `empty` high.
- R9: `busy` is high from the cycle after a walk starts until its final cycle without strobes. Requests arriving while `busy` is high are ignored.
- R10: When requests coincide in idle, flush takes precedence over squash, and squash takes precedence over commit.
- R11: After reset the list is empty, `busy` is low and no strobe is active.
- R12: The commit decision uses the records held before that cycle's push. A record pushed in the same cycle as an accepted commit is still retired by that walk if its number is at or below C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Offer a new rename record |
| push_seq | input | SEQ_W | Sequence number of the record |
| push_areg | input | AREG_W | Architectural register of the record |
| push_new_preg | input | PREG_W | Newly allocated physical register |
| push_prev_preg | input | PREG_W | Displaced physical register |
| push_ok | output | 1 | The record offered this cycle is stored |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| commit_squash | input | 1 | Commit also signals a squash this cycle |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Last surviving sequence number |
| flush_valid | input | 1 | Undo every record |
| busy | output | 1 | A walk is in progress |
| empty | output | 1 | No records held |
| full | output | 1 | DEPTH records held |
| map_wr_en | output | 1 | Map-table restore strobe |
| map_wr_areg | output | AREG_W | Architectural register to restore |
| map_wr_preg | output | PREG_W | Physical register written into the map |
| free_en | output | 1 | Free-list return strobe |
| free_preg | output | PREG_W | Physical register returned |
| ready_en | output | 1 | Scoreboard-ready strobe |
| ready_preg | output | PREG_W | Physical register marked ready |

## Verification
A push and the start of a commit walk can be accepted in the same idle cycle. The bench provokes this by pushing a record while issuing a commit. It uses a number that covers the older records but not the new one, and elsewhere it issues a commit on an empty list together with a push. It judges the result against a queue model: the accept decision follows the records held before the push, and the walk sees the pushed record. It also places a squash inside a running commit walk and checks that the walk's strobes match the commit alone.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COMMIT,
        ST_SQUASH,
        ST_FLUSH
    } walk_state_t;
endpackage

// File: rtl/rhb_ring.sv
module rhb_ring #(
    parameter int DEPTH = 8,
    parameter int W     = 27
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_en,
    input  logic [W-1:0] push_rec,
    input  logic         pop_old,
    input  logic         pop_young,
    output logic [W-1:0] old_rec,
    output logic [W-1:0] young_rec,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr, young_ptr;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] inc_ptr(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + PW'(1);
    endfunction

    function automatic logic [PW-1:0] dec_ptr(input logic [PW-1:0] p);
        return (p == '0) ? LAST : p - PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_en) mem[wr_ptr] <= push_rec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_en)        wr_ptr <= inc_ptr(wr_ptr);
            else if (pop_young) wr_ptr <= dec_ptr(wr_ptr);
            if (pop_old)        rd_ptr <= inc_ptr(rd_ptr);
            if (push_en && !(pop_old || pop_young))      cnt <= cnt + CW'(1);
            else if (!push_en && (pop_old || pop_young)) cnt <= cnt - CW'(1);
        end
    end

    assign young_ptr = dec_ptr(wr_ptr);
    assign old_rec   = mem[rd_ptr];
    assign young_rec = mem[young_ptr];
    assign empty     = (cnt == '0);
    assign full      = (cnt == CW'(DEPTH));

    // R1: a full ring never takes a write
    assert_no_push_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push_en);
    // R9: popping happens only when records exist, from one end at a time
    assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_old || pop_young) |-> (!empty && !(pop_old && pop_young)));
endmodule

// File: rtl/rhb_ctrl.sv
module rhb_ctrl
    import rhb_pkg::*;
#(
    parameter int SEQ_W    = 8,
    parameter int AREG_W   = 5,
    parameter int PREG_W   = 7,
    parameter int NUM_PHYS = 96,
    parameter int W        = SEQ_W + AREG_W + 2 * PREG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              commit_squash,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              flush_valid,
    input  logic [W-1:0]      old_rec,
    input  logic [W-1:0]      young_rec,
    input  logic              empty,
    input  logic              full,
    output logic              push_en,
    output logic              push_ok,
    output logic              pop_old,
    output logic              pop_young,
    output logic              busy,
    output logic              map_wr_en,
    output logic [AREG_W-1:0] map_wr_areg,
    output logic [PREG_W-1:0] map_wr_preg,
    output logic              free_en,
    output logic [PREG_W-1:0] free_preg,
    output logic              ready_en,
    output logic [PREG_W-1:0] ready_preg
);
    localparam int LOW_W = AREG_W + 2 * PREG_W;

    walk_state_t       state, state_nx;
    logic [SEQ_W-1:0]  limit_q, limit_nx;
    logic [SEQ_W-1:0]  o_seq, y_seq;
    logic [LOW_W-1:0]  sel_low;
    logic [AREG_W-1:0] s_areg;
    logic [PREG_W-1:0] s_new, s_prev;
    logic              flush_go, squash_go, commit_go;
    logic              step, commit_step, undo_step;

    assign o_seq = old_rec[W-1 -: SEQ_W];
    assign y_seq = young_rec[W-1 -: SEQ_W];
    assign sel_low = (state == ST_COMMIT) ? old_rec[LOW_W-1:0] : young_rec[LOW_W-1:0];
    assign {s_areg, s_new, s_prev} = sel_low;

    assign flush_go  = flush_valid && !empty;
    assign squash_go = !flush_valid && squash_valid && !empty && (y_seq > squash_seq);
    assign commit_go = !flush_valid && !squash_valid && commit_valid && !commit_squash
                       && !empty && (o_seq <= commit_seq);

    always_comb begin
        step = 1'b0;
        unique case (state)
            ST_COMMIT: step = !empty && (o_seq <= limit_q);
            ST_SQUASH: step = !empty && (y_seq > limit_q);
            ST_FLUSH:  step = !empty;
            default:   step = 1'b0;
        endcase
    end

    always_comb begin
        state_nx = state;
        limit_nx = limit_q;
        unique case (state)
            ST_IDLE: begin
                if (flush_go) begin
                    state_nx = ST_FLUSH;
                end else if (squash_go) begin
                    state_nx = ST_SQUASH;
                    limit_nx = squash_seq;
                end else if (commit_go) begin
                    state_nx = ST_COMMIT;
                    limit_nx = commit_seq;
                end
            end
            default: if (!step) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            limit_q <= '0;
        end else begin
            state   <= state_nx;
            limit_q <= limit_nx;
        end
    end

    always_comb begin
        busy        = (state != ST_IDLE);
        push_ok     = !busy && !full && !flush_valid && !squash_valid;
        push_en     = push_ok && push_valid;
        commit_step = step && (state == ST_COMMIT);
        undo_step   = step && (state != ST_COMMIT);
        pop_old     = commit_step;
        pop_young   = undo_step;
        free_en     = step;
        free_preg   = commit_step ? s_prev : (undo_step ? s_new : '0);
        map_wr_en   = undo_step;
        map_wr_areg = undo_step ? s_areg : '0;
        map_wr_preg = undo_step ? s_prev : '0;
        ready_en    = undo_step && (int'(s_new) >= NUM_PHYS);
        ready_preg  = ready_en ? s_new : '0;
    end

    // R5: retiring never touches the map
    assert_commit_no_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |-> !map_wr_en);
    // R3: ready strobes only for registers above the file, alongside an undo
    assert_ready_misc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready_en |-> (map_wr_en && free_en && int'(ready_preg) >= NUM_PHYS));
    // R6: a stale commit in idle does not start a walk
    assert_stale_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !flush_valid && !squash_valid && commit_valid && !empty
         && (o_seq > commit_seq)) |=> !busy);
    // R8: a flush ends once the ring is drained
    assert_flush_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH && empty) |=> !busy);
    // R9: no record is stored during a walk
    assert_push_refused_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !push_en);
endmodule

// File: rtl/rename_hist_buf.sv
module rename_hist_buf #(
    parameter int DEPTH    = 8,
    parameter int SEQ_W    = 8,
    parameter int AREG_W   = 5,
    parameter int PREG_W   = 7,
    parameter int NUM_PHYS = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [SEQ_W-1:0]  push_seq,
    input  logic [AREG_W-1:0] push_areg,
    input  logic [PREG_W-1:0] push_new_preg,
    input  logic [PREG_W-1:0] push_prev_preg,
    output logic              push_ok,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              commit_squash,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              flush_valid,
    output logic              busy,
    output logic              empty,
    output logic              full,
    output logic              map_wr_en,
    output logic [AREG_W-1:0] map_wr_areg,
    output logic [PREG_W-1:0] map_wr_preg,
    output logic              free_en,
    output logic [PREG_W-1:0] free_preg,
    output logic              ready_en,
    output logic [PREG_W-1:0] ready_preg
);
    localparam int REC_W = SEQ_W + AREG_W + 2 * PREG_W;

    logic [REC_W-1:0] old_rec, young_rec, push_rec;
    logic             push_en, pop_old, pop_young;

    assign push_rec = {push_seq, push_areg, push_new_preg, push_prev_preg};

    rhb_ring #(.DEPTH(DEPTH), .W(REC_W)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_en),
        .push_rec  (push_rec),
        .pop_old   (pop_old),
        .pop_young (pop_young),
        .old_rec   (old_rec),
        .young_rec (young_rec),
        .empty     (empty),
        .full      (full)
    );

    rhb_ctrl #(
        .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W),
        .NUM_PHYS(NUM_PHYS), .W(REC_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .push_valid    (push_valid),
        .commit_valid  (commit_valid),
        .commit_seq    (commit_seq),
        .commit_squash (commit_squash),
        .squash_valid  (squash_valid),
        .squash_seq    (squash_seq),
        .flush_valid   (flush_valid),
        .old_rec       (old_rec),
        .young_rec     (young_rec),
        .empty         (empty),
        .full          (full),
        .push_en       (push_en),
        .push_ok       (push_ok),
        .pop_old       (pop_old),
        .pop_young     (pop_young),
        .busy          (busy),
        .map_wr_en     (map_wr_en),
        .map_wr_areg   (map_wr_areg),
        .map_wr_preg   (map_wr_preg),
        .free_en       (free_en),
        .free_preg     (free_preg),
        .ready_en      (ready_en),
        .ready_preg    (ready_preg)
    );
endmodule

// File: tb/test_rename_hist_buf.sv
module test_rename_hist_buf;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8, SEQ_W = 8, AREG_W = 5, PREG_W = 7, NUM_PHYS = 96;

    logic clk, rst_n;
    logic push_valid, push_ok, commit_valid, commit_squash, squash_valid, flush_valid;
    logic [SEQ_W-1:0] push_seq, commit_seq, squash_seq;
    logic [AREG_W-1:0] push_areg, map_wr_areg;
    logic [PREG_W-1:0] push_new_preg, push_prev_preg, map_wr_preg, free_preg, ready_preg;
    logic busy, empty, full, map_wr_en, free_en, ready_en;

    rename_hist_buf #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W),
                      .PREG_W(PREG_W), .NUM_PHYS(NUM_PHYS)) i_rename_hist_buf (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_seq(push_seq),
        .push_areg(push_areg), .push_new_preg(push_new_preg),
        .push_prev_preg(push_prev_preg), .push_ok(push_ok),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .commit_squash(commit_squash), .squash_valid(squash_valid),
        .squash_seq(squash_seq), .flush_valid(flush_valid), .busy(busy),
        .empty(empty), .full(full), .map_wr_en(map_wr_en),
        .map_wr_areg(map_wr_areg), .map_wr_preg(map_wr_preg),
        .free_en(free_en), .free_preg(free_preg), .ready_en(ready_en),
        .ready_preg(ready_preg));

    int n_checks = 0, n_fail = 0;
    int m_seq[DEPTH], m_areg[DEPTH], m_new[DEPTH], m_prev[DEPTH];
    int mc = 0;

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        push_valid = 0; commit_valid = 0; commit_squash = 0;
        squash_valid = 0; flush_valid = 0;
    endtask

    // mode: 0 none, 1 commit, 2 squash, 3 flush
    task automatic run_op(input bit pv, input int ps, input int pa, input int pn, input int pp,
                          input bit cv, input int cs, input bit csq,
                          input bit sv, input int ss, input bit fv,
                          input bit inj, input string tag);
        int mode; bit pre_empty, ok; int pre_old, pre_young;
        push_valid = pv; push_seq = SEQ_W'(ps); push_areg = AREG_W'(pa);
        push_new_preg = PREG_W'(pn); push_prev_preg = PREG_W'(pp);
        commit_valid = cv; commit_seq = SEQ_W'(cs); commit_squash = csq;
        squash_valid = sv; squash_seq = SEQ_W'(ss); flush_valid = fv;
        #1;
        ok = (mc < DEPTH) && !sv && !fv;
        chk(tag, "push_ok", int'(push_ok), int'(ok));
        pre_empty = (mc == 0);
        pre_old   = pre_empty ? 0 : m_seq[0];
        pre_young = pre_empty ? 0 : m_seq[mc - 1];
        if (pv && ok) begin
            m_seq[mc] = ps; m_areg[mc] = pa; m_new[mc] = pn; m_prev[mc] = pp; mc++;
        end
        if (fv)      mode = pre_empty ? 0 : 3;
        else if (sv) mode = (!pre_empty && pre_young > ss) ? 2 : 0;
        else         mode = (cv && !csq && !pre_empty && pre_old <= cs) ? 1 : 0;
        @(negedge clk);
        clear_inputs();
        if (inj) begin squash_valid = 1; squash_seq = '0; end
        if (mode == 0) begin
            chk(tag, "busy idle", int'(busy), 0);
            chk(tag, "free_en idle", int'(free_en), 0);
            chk(tag, "map_wr_en idle", int'(map_wr_en), 0);
            @(negedge clk);
            squash_valid = 0;
            chk(tag, "busy after", int'(busy), 0);
            return;
        end
        forever begin
            bit st;
            st = (mode == 1) ? (mc > 0 && m_seq[0] <= cs) :
                 (mode == 2) ? (mc > 0 && m_seq[mc - 1] > ss) : (mc > 0);
            if (!st) break;
            chk(tag, "busy walk", int'(busy), 1);
            chk(tag, "free_en", int'(free_en), 1);
            if (mode == 1) begin
                chk(tag, "free_preg commit", int'(free_preg), m_prev[0]);
                chk(tag, "map_wr_en commit", int'(map_wr_en), 0);
                for (int i = 0; i < mc - 1; i++) begin
                    m_seq[i] = m_seq[i + 1]; m_areg[i] = m_areg[i + 1];
                    m_new[i] = m_new[i + 1]; m_prev[i] = m_prev[i + 1];
                end
            end else begin
                chk(tag, "map_wr_en undo", int'(map_wr_en), 1);
                chk(tag, "map_wr_areg", int'(map_wr_areg), m_areg[mc - 1]);
                chk(tag, "map_wr_preg", int'(map_wr_preg), m_prev[mc - 1]);
                chk(tag, "free_preg undo", int'(free_preg), m_new[mc - 1]);
                chk(tag, "ready_en R3", int'(ready_en), int'(m_new[mc - 1] >= NUM_PHYS));
                if (m_new[mc - 1] >= NUM_PHYS)
                    chk(tag, "ready_preg R3", int'(ready_preg), m_new[mc - 1]);
            end
            mc--;
            @(negedge clk);
            squash_valid = 0;
        end
        chk(tag, "busy tail", int'(busy), 1);
        chk(tag, "free_en tail", int'(free_en), 0);
        chk(tag, "map_wr_en tail", int'(map_wr_en), 0);
        @(negedge clk);
        squash_valid = 0;
        chk(tag, "busy done", int'(busy), 0);
        chk(tag, "empty", int'(empty), int'(mc == 0));
        chk(tag, "full", int'(full), int'(mc == DEPTH));
    endtask

    task automatic push(input int s, input int a, input int n, input int p, input string tag);
        run_op(1, s, a, n, p, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic do_commit(input int c, input bit csq, input bit inj, input string tag);
        run_op(0, 0, 0, 0, 0, 1, c, csq, 0, 0, 0, inj, tag);
    endtask
    task automatic do_squash(input int s, input string tag);
        run_op(0, 0, 0, 0, 0, 0, 0, 0, 1, s, 0, 0, tag);
    endtask
    task automatic do_flush(input string tag);
        run_op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, tag);
    endtask
    task automatic fill_odd(input string tag);
        for (int i = 0; i < DEPTH; i++) push(2 * i + 1, i + 2, 90 + i, 30 + i, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0;
        clear_inputs();
        push_seq = '0; push_areg = '0; push_new_preg = '0; push_prev_preg = '0;
        commit_seq = '0; squash_seq = '0;
        repeat (3) @(negedge clk);
        chk("R11", "empty", int'(empty), 1);
        chk("R11", "full", int'(full), 0);
        chk("R11", "busy", int'(busy), 0);
        chk("R11", "free_en", int'(free_en), 0);
        chk("R11", "map_wr_en", int'(map_wr_en), 0);
        chk("R11", "ready_en", int'(ready_en), 0);
        rst_n = 1;
        @(negedge clk);

        do_squash(0, "R4 empty");
        do_commit(5, 0, 0, "R6 empty");
        // R12: commit on an empty ring with a concurrent push is ignored
        run_op(1, 3, 1, 20, 21, 1, 9, 0, 0, 0, 0, 0, "R12 empty");
        do_flush("R8 single");

        for (int i = 0; i < DEPTH; i++) push(10 + i, i + 1, 90 + i, 40 + i, "R1 fill");
        chk("R1", "full", int'(full), 1);
        push(50, 9, 9, 9, "R1 overfull");
        do_commit(5, 0, 0, "R6 stale");
        do_commit(12, 0, 0, "R5 retire");
        do_commit(20, 1, 0, "R7 commit_squash");
        run_op(0, 0, 0, 0, 0, 1, 20, 0, 1, 200, 0, 0, "R7 squash_valid");
        do_squash(15, "R2 R3 undo");
        do_squash(20, "R4 nothing younger");
        run_op(1, 18, 7, 100, 50, 1, 13, 0, 0, 0, 0, 0, "R12 push with commit");
        run_op(1, 19, 8, 101, 51, 1, 19, 0, 0, 0, 0, 0, "R12 pushed record retired");
        push(20, 3, 60, 61, "R1");
        push(21, 4, 62, 63, "R1");
        do_commit(30, 0, 1, "R9 squash during walk");
        push(40, 1, 97, 2, "R1");
        push(41, 2, 98, 3, "R1");
        push(42, 3, 5, 4, "R1");
        run_op(0, 0, 0, 0, 0, 1, 255, 0, 1, 0, 1, 0, "R10 flush wins");
        push(50, 5, 10, 11, "R1");
        push(51, 6, 12, 13, "R1");
        run_op(0, 0, 0, 0, 0, 1, 255, 0, 1, 50, 0, 0, "R10 squash wins");
        do_flush("R8 drain");

        for (int k = 0; k <= DEPTH; k++) begin
            fill_odd("R1 sweep");
            do_squash(2 * k, "R2 sweep");
            do_flush("R8 sweep");
        end
        for (int k = 0; k <= DEPTH; k++) begin
            fill_odd("R1 sweep");
            do_commit(2 * k, 0, 0, "R5 sweep");
            do_flush("R8 sweep");
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule